// File: doc/BRIEF.md
# Write-one set/clear status controller

This block keeps the mode and error state of a serial shift controller: an operational-enable bit, a master-select bit and six error flags (mode, transmit overflow, receive overflow, abort, transmit underflow, receive underflow). Software reads all of them through one read-only status word. It changes them through a write-only command word that gives every flag its own set strobe and its own clear strobe. A zero in a strobe position means "no change", so software never has to read, modify and write back the word.

Hardware error events raise the error flags, each one gated by a detection-enable bit in a held control word. The mode error has no enable and is always captured. A combined error interrupt is high while any error flag is set. The control word also carries the shift-engine settings. It can only be written while the controller is in configuration mode, which means enable is 0.

Top module: `ssc_flag_ctrl`

## Requirements
- R1: After reset the status word is zero apart from the busy mirror, the interrupt is low, and the control word equals the CFG_RST parameter (default 0x1F00).
- R2: A command write with bit1 set makes enable 1 and with bit0 set makes enable 0. Bit3 sets master select and bit2 clears it. If a flag's set and clear strobes are both 1 in one write, that flag keeps its value.
- R3: The error flags follow these command strobes. Mode error is cleared by bit6 and set by bit7. Receive underflow is cleared by bit4 and set by bit5. Transmit overflow, receive overflow, abort and transmit underflow are cleared by bits 8, 9, 10 and 11, and set by bits 12, 13, 14 and 15. If a flag's set and clear strobes are both 1, the flag is unchanged.
- R4: Zero strobe bits leave their flags unchanged. With no command write and no event, nothing in the status word changes.
- R5: A pulse on err_evt sets the matching error flag at the next clock edge. err_evt bit0 is mode error and is always captured. Bits 1 to 5 are transmit overflow, receive overflow, abort, transmit underflow and receive underflow. Each of these is captured only when control-word bits 8, 9, 10, 11 and 12 respectively are 1. A disabled event is ignored.
- R6: An enabled error event wins over a software clear of the same flag in the same cycle, so the flag is set.
- R7: err_irq is 1 exactly while at least one error flag is set. It stays high until the flags are cleared by command.
- R8: The status word carries enable at bit0, master select at bit1, mode error at bit7, transmit overflow at bit8, receive overflow at bit9, abort at bit10, transmit underflow at bit11 and receive underflow at bit12. Bit13 shows the busy input in the same cycle. All other bits are 0.
- R9: A control-word write is taken at the next edge only while enable is 0, judged by the enable value before that edge. While enable is 1 the write is ignored.
- R10: One command write of 0x0F58 clears all six error flags and sets master select in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 16 | Command word: set/clear strobes |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | CFG_W | Control word write data |
| err_evt | input | 6 | Hardware error event pulses |
| busy_in | input | 1 | Shift engine busy indication |
| status_o | output | 16 | Status word |
| cfg_o | output | CFG_W | Held control word |
| err_irq | output | 1 | Combined error interrupt |

## Verification
Command writes, control-word writes and error events are all registered, so their effect shows on status_o, cfg_o and err_irq one clock edge after the cycle in which they are presented. The busy bit is combinational and appears in the same cycle. The bench drives its inputs just after a falling edge and keeps them for exactly one rising edge. Its reference model updates on that rising edge, and both the model and the directed checks compare the outputs at the following falling edge. Each result is therefore examined in the first cycle it is due, and never in the cycle before.

// File: rtl/ssc_flag_ctrl.sv
module ssc_flag_ctrl #(
  parameter int CFG_W = 16,
  parameter logic [CFG_W-1:0] CFG_RST = CFG_W'(16'h1F00)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [15:0]      cmd_wdata,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [5:0]       err_evt,
  input  logic             busy_in,
  output logic [15:0]      status_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             err_irq
);

  localparam int NERR = 6;

  logic            en_q, ms_q;
  logic [NERR-1:0] err_q;
  logic [CFG_W-1:0] cfg_q;

  // index: 0 mode, 1 tx ovf, 2 rx ovf, 3 abort, 4 tx unf, 5 rx unf
  wire [NERR-1:0] clr_s = cmd_we ? {cmd_wdata[4], cmd_wdata[11:8], cmd_wdata[6]} : '0;
  wire [NERR-1:0] set_s = cmd_we ? {cmd_wdata[5], cmd_wdata[15:12], cmd_wdata[7]} : '0;
  wire [NERR-1:0] gate  = {cfg_q[12:8], 1'b1};
  wire [NERR-1:0] hit   = err_evt & gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ms_q  <= 1'b0;
      err_q <= '0;
      cfg_q <= CFG_RST;
    end else begin
      if (cmd_we && (cmd_wdata[1] ^ cmd_wdata[0])) en_q <= cmd_wdata[1];
      if (cmd_we && (cmd_wdata[3] ^ cmd_wdata[2])) ms_q <= cmd_wdata[3];
      if (cfg_we && !en_q) cfg_q <= cfg_wdata;
      err_q <= hit | (set_s & ~clr_s) | (err_q & ~(clr_s & ~set_s));
    end
  end

  assign status_o = {2'b00, busy_in, err_q, 5'b00000, ms_q, en_q};
  assign cfg_o    = cfg_q;
  assign err_irq  = |err_q;

  a_r2_both_en: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_wdata[1] && cmd_wdata[0] |=> $stable(status_o[0]));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we && err_evt == 6'd0 |=> $stable(status_o[12:0]));

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    |(err_evt & {cfg_o[12:8], 1'b1}) |=> err_irq);

  a_r6_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt[3] && cfg_o[10] |=> status_o[10]);

  a_r7_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_irq) |-> $past(cmd_we));

  a_r9_locked: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && status_o[0] |=> $stable(cfg_o));

endmodule

// File: tb/test_ssc_flag_ctrl.sv
`timescale 1ns/1ps
module test_ssc_flag_ctrl;
  localparam int CFG_W = 16;

  logic clk = 0, rst_n = 0;
  logic cmd_we = 0, cfg_we = 0, busy_in = 0;
  logic [15:0] cmd_wdata = '0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic [5:0] err_evt = '0;
  logic [15:0] status_o;
  logic [CFG_W-1:0] cfg_o;
  logic err_irq;

  ssc_flag_ctrl #(.CFG_W(CFG_W)) i_ssc_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .err_evt(err_evt),
    .busy_in(busy_in), .status_o(status_o), .cfg_o(cfg_o), .err_irq(err_irq));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  string phase = "R1";

  // reference model
  bit m_en, m_ms;
  bit m_err [6];
  logic [CFG_W-1:0] m_cfg;
  int clr_pos [6] = '{6, 8, 9, 10, 11, 4};
  int set_pos [6] = '{7, 12, 13, 14, 15, 5};
  int ena_pos [6] = '{-1, 8, 9, 10, 11, 12};
  bit ok [6];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_ms = 0; m_cfg = 16'h1F00;
      foreach (m_err[i]) m_err[i] = 0;
    end else begin
      foreach (ok[i]) ok[i] = (ena_pos[i] < 0) ? 1'b1 : m_cfg[ena_pos[i]];
      if (cfg_we && !m_en) m_cfg = cfg_wdata;
      if (cmd_we) begin
        if (cmd_wdata[1] && !cmd_wdata[0]) m_en = 1;
        else if (cmd_wdata[0] && !cmd_wdata[1]) m_en = 0;
        if (cmd_wdata[3] && !cmd_wdata[2]) m_ms = 1;
        else if (cmd_wdata[2] && !cmd_wdata[3]) m_ms = 0;
        foreach (m_err[i]) begin
          if (cmd_wdata[set_pos[i]] && !cmd_wdata[clr_pos[i]]) m_err[i] = 1;
          else if (cmd_wdata[clr_pos[i]] && !cmd_wdata[set_pos[i]]) m_err[i] = 0;
        end
      end
      foreach (m_err[i]) if (err_evt[i] && ok[i]) m_err[i] = 1;
    end
  end

  function automatic logic [15:0] m_status();
    logic [15:0] s = '0;
    s[0] = m_en; s[1] = m_ms; s[13] = busy_in;
    foreach (m_err[i]) s[7+i] = m_err[i];
    return s;
  endfunction

  function automatic bit m_irq();
    bit a = 0;
    foreach (m_err[i]) a |= m_err[i];
    return a;
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) if (rst_n && !finished) begin
    chk(phase, "model status", 32'(status_o), 32'(m_status()));
    chk(phase, "model irq", 32'(err_irq), 32'(m_irq()));
    chk(phase, "model cfg", 32'(cfg_o), 32'(m_cfg));
  end

  task automatic drive(bit cw, logic [15:0] c, bit fw, logic [15:0] f, logic [5:0] e);
    @(negedge clk); #1;
    cmd_we = cw; cmd_wdata = c; cfg_we = fw; cfg_wdata = f; err_evt = e;
    @(posedge clk); #1;
    cmd_we = 0; cmd_wdata = '0; cfg_we = 0; cfg_wdata = '0; err_evt = '0;
    @(negedge clk);
  endtask

  task automatic cmd(logic [15:0] c); drive(1, c, 0, '0, '0); endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    phase = "R1";
    chk("R1", "reset status", 32'(status_o), 32'h0);
    chk("R1", "reset irq", 32'(err_irq), 32'h0);
    chk("R1", "reset cfg", 32'(cfg_o), 32'h1F00);

    phase = "R2";
    cmd(16'h0002); chk("R2", "enable set", 32'(status_o), 32'h0001);
    cmd(16'h0008); chk("R2", "master set", 32'(status_o), 32'h0003);
    cmd(16'h0003); chk("R2", "enable both strobes", 32'(status_o), 32'h0003);

    phase = "R9";
    drive(0, '0, 1, 16'h0000, '0); chk("R9", "cfg locked", 32'(cfg_o), 32'h1F00);
    cmd(16'h0001); chk("R2", "enable clear", 32'(status_o), 32'h0002);
    drive(0, '0, 1, 16'h0A55, '0); chk("R9", "cfg open", 32'(cfg_o), 32'h0A55);
    drive(0, '0, 1, 16'h1F00, '0);

    phase = "R3";
    cmd(16'hF0A0); chk("R3", "set all errors", 32'(status_o), 32'h1F82);
    chk("R7", "irq high", 32'(err_irq), 32'h1);
    phase = "R4";
    cmd(16'h0000); chk("R4", "zero write", 32'(status_o), 32'h1F82);
    repeat (3) @(negedge clk);
    chk("R7", "irq held", 32'(err_irq), 32'h1);
    phase = "R3";
    cmd(16'h0F50); chk("R3", "clear all errors", 32'(status_o), 32'h0002);
    chk("R7", "irq low", 32'(err_irq), 32'h0);
    cmd(16'h4400); chk("R3", "abort both strobes", 32'(status_o), 32'h0002);

    phase = "R10";
    cmd(16'h0004); chk("R2", "master clear", 32'(status_o), 32'h0000);
    cmd(16'hF0A0);
    cmd(16'h0F58); chk("R10", "clear errors and set master", 32'(status_o), 32'h0002);

    phase = "R5";
    drive(0, '0, 0, '0, 6'h3F); chk("R5", "all events enabled", 32'(status_o), 32'h1F82);
    cmd(16'h0F50);
    drive(0, '0, 1, 16'h0000, '0);
    drive(0, '0, 0, '0, 6'h3F); chk("R5", "only mode error captured", 32'(status_o), 32'h0082);
    cmd(16'h0F50);
    drive(0, '0, 1, 16'h0400, '0);
    drive(0, '0, 0, '0, 6'h08); chk("R5", "abort enabled alone", 32'(status_o), 32'h0402);
    drive(0, '0, 1, 16'h1F00, '0);

    phase = "R6";
    drive(1, 16'h0400, 0, '0, 6'h08); chk("R6", "event beats clear", 32'(status_o), 32'h0402);
    cmd(16'h0400); chk("R6", "clear after", 32'(status_o), 32'h0002);

    phase = "R8";
    #1 busy_in = 1;
    @(negedge clk); chk("R8", "busy bit", 32'(status_o), 32'h2002);
    busy_in = 0;

    phase = "R9";
    for (int k = 0; k < 400; k++) begin
      drive($urandom_range(0, 2) == 0, 16'($urandom), $urandom_range(0, 1) == 1,
            16'($urandom), ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'd0);
      busy_in = $urandom_range(0, 1) == 1;
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule